// File: doc/BRIEF.md
# I2C Bus Target with 7-bit and 10-bit Addressing

This block is the target (slave) side of an I2C bus. Both bus lines are open-drain. Each line is seen as a raw input plus a drive-low enable that pulls the wire down. The block resynchronises both lines and detects START, repeated START and STOP. It compares the incoming address against a programmable own address, either as a 7-bit address or through the two-byte 10-bit sequence. It then acknowledges and either receives data or transmits data.

Received bits collect in a shift register. A finished byte moves into a separate receive buffer, with a one-cycle interrupt pulse. If the buffer is still unread when the next byte finishes, that byte is refused and an overflow flag is raised. For reads, the block holds SCL low after the address has been accepted. It keeps SCL low until software has loaded the transmit holding register and issued a clock-release strobe. It repeats this hold before every further byte the master asks for.

The control and status values are plain ports. No register decode is included.

Top module: `i2c_target_port`

## Requirements
- R1: After reset both drive-low enables are 0, and `rx_full_o`, `rx_ovf_o`, `rx_irq_o`, `selected_o` and `tx_full_o` are 0.
- R2: A START (SDA falling while SCL is high) begins address reception from any state, including a repeated START inside a transfer. A STOP (SDA rising while SCL is high) releases both lines and clears `selected_o`.
- R3: With `addr10_i`=0, bits 7:1 of the first byte are compared with `own_addr_i[6:0]`, and bit 0 is the direction (1 = read). On a match, SDA is pulled low during the ninth SCL clock, `selected_o` becomes 1, and `dir_read_o` takes the direction bit.
- R4: On an address mismatch SDA is never pulled low. Later bytes of that transfer get no acknowledge, do not reach the receive buffer and give no interrupt, until the next START.
- R5: With `addr10_i`=1, a first byte of 1111_0, `own_addr_i[9:8]`, 0 is acknowledged. A second byte equal to `own_addr_i[7:0]` is then acknowledged and write data follows. A different second byte, or a first byte with other bits 9:8, gets no acknowledge.
- R6: With `addr10_i`=1, a first byte of 1111_0, `own_addr_i[9:8]`, 1 is acknowledged and starts a read only if a full 10-bit write match took place earlier in the same transfer (since the last STOP). Otherwise it gets no acknowledge.
- R7: Each data byte received while the buffer is empty is acknowledged, appears on `rx_data_o` with `rx_full_o`=1, and gives exactly one cycle of `rx_irq_o`. A pulse on `rx_read_i` clears `rx_full_o`.
- R8: A data byte that completes while `rx_full_o`=1 is not acknowledged and leaves `rx_data_o` unchanged. It sets `rx_ovf_o`, which stays set until a pulse on `rx_ovf_clr_i`.
- R9: After a read address is acknowledged, SCL is held low. `clk_release_i` frees SCL only while the transmit register is loaded (`tx_full_o`=1). A release with an empty register is ignored, and a taken release clears `tx_full_o`.
- R10: Read bytes are sent MSB first. After a master ACK (SDA low in the ninth clock) SCL is held again for the next byte. After a NACK, SDA stays released until the next START.
- R11: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL wire |
| sda_i | input | 1 | Sensed level of the SDA wire |
| scl_drive_low_o | output | 1 | 1 pulls SCL low (clock hold) |
| sda_drive_low_o | output | 1 | 1 pulls SDA low (ACK or data 0) |
| addr10_i | input | 1 | 1 selects 10-bit address comparison |
| own_addr_i | input | 10 | Own address; bits 6:0 used in 7-bit mode |
| tx_data_i | input | 8 | Byte to load into the transmit holding register |
| tx_load_i | input | 1 | Strobe: load `tx_data_i` |
| clk_release_i | input | 1 | Strobe: release a held SCL |
| tx_full_o | output | 1 | Transmit holding register loaded and not yet taken |
| rx_data_o | output | 8 | Receive buffer |
| rx_full_o | output | 1 | Receive buffer holds an unread byte |
| rx_read_i | input | 1 | Strobe: receive buffer has been read |
| rx_irq_o | output | 1 | One-cycle pulse on each byte moved to the buffer |
| rx_ovf_o | output | 1 | Sticky overflow flag |
| rx_ovf_clr_i | input | 1 | Strobe: clear the overflow flag |
| selected_o | output | 1 | Addressed in the current transfer |
| dir_read_o | output | 1 | Current transfer is a read |

## Verification
The bench sends a second data byte while the buffer is still unread. A design that overwrites the buffer would change `rx_data_o` and acknowledge the byte instead of refusing it. In 10-bit mode it sends a read header after a repeated START, once after a full write match and once after a failed second byte and a STOP. A design that keys the read only on the header bits would wrongly acknowledge the second case. During the clock hold it releases the master's own SCL and strobes release with an empty transmit register. A design that ignores the load condition would let SCL rise and shift out stale data. After a master NACK it clocks extra bits and expects all ones, which catches a design that keeps driving the next byte.

// File: rtl/i2c_tgt_pkg.sv
// Shared constants and state types for the I2C target.
// Assumes 8-bit bytes and the 10-bit header tag fixed by the bus protocol.
package i2c_tgt_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR10_W = 10;
    localparam logic [4:0] HI_TAG = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,     // no transfer in progress
        ST_RX,       // shifting in a byte
        ST_ACK_OUT,  // ninth clock, target may drive ACK
        ST_TX,       // shifting out a byte (or holding SCL before it)
        ST_ACK_IN,   // ninth clock of a read, master answers
        ST_IGNORE    // not addressed, wait for START or STOP
    } tgt_state_t;

    typedef enum logic [1:0] {
        RX_ADDR1,
        RX_ADDR2,
        RX_DATA
    } rx_kind_t;

    typedef enum logic [1:0] {
        NX_DATA_W,
        NX_ADDR2,
        NX_READ
    } after_ack_t;
endpackage

// File: rtl/i2c_line_sampler.sv
// Resynchronises SCL and SDA through a flop chain and derives SCL edges
// and START/STOP conditions. Assumes both lines idle high, so the chain
// resets to 1. Outputs are single-cycle strobes in the clk domain.
module i2c_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // Flop chain for one bus line.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    // Previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= synced;
    end

    assign scl_s     = synced[0];
    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] & prev[0];
    assign start_det = synced[0] & prev[0] & ~synced[1] & prev[1];
    assign stop_det  = synced[0] & prev[0] & synced[1] & ~prev[1];
endmodule

// File: rtl/i2c_rx_holding.sv
// Receive buffer behind the shift register. Takes a finished byte when
// empty (with a one-cycle interrupt pulse) and flags overflow when full.
// Assumes deliver_i pulses at most once per received byte.
module i2c_rx_holding #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         deliver_i,
    input  logic [W-1:0] byte_i,
    input  logic         pop_i,
    input  logic         ovf_clr_i,
    output logic [W-1:0] data_o,
    output logic         full_o,
    output logic         ovf_o,
    output logic         irq_o
);
    logic take;
    assign take = deliver_i & ~full_o;

    // Buffer contents, occupancy and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            full_o <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            irq_o <= take;
            if (take) begin
                data_o <= byte_i;
                full_o <= 1'b1;
            end else if (pop_i) begin
                full_o <= 1'b0;
            end
        end
    end

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ovf_o <= 1'b0;
        else if (deliver_i && full_o)  ovf_o <= 1'b1;
        else if (ovf_clr_i)            ovf_o <= 1'b0;
    end

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R7
    AST_OVF_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_i && full_o) |=> $stable(data_o)); // R8
endmodule

// File: rtl/i2c_target_port.sv
// I2C bus target with 7-bit or 10-bit own address, double-buffered
// receive path and software-released clock hold for reads.
// Assumes open-drain lines: a 1 on a drive-low output pulls the wire low.
// SDA is changed only on detected SCL falls or while this block holds SCL.
module i2c_target_port
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                scl_drive_low_o,
    output logic                sda_drive_low_o,
    input  logic                addr10_i,
    input  logic [ADDR10_W-1:0] own_addr_i,
    input  logic [BYTE_W-1:0]   tx_data_i,
    input  logic                tx_load_i,
    input  logic                clk_release_i,
    output logic                tx_full_o,
    output logic [BYTE_W-1:0]   rx_data_o,
    output logic                rx_full_o,
    input  logic                rx_read_i,
    output logic                rx_irq_o,
    output logic                rx_ovf_o,
    input  logic                rx_ovf_clr_i,
    output logic                selected_o,
    output logic                dir_read_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    tgt_state_t        state;
    rx_kind_t          kind;
    after_ack_t        after;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_shift;
    logic [BYTE_W-1:0] tx_shift;
    logic [BYTE_W-1:0] tx_hold;
    logic              stretch;
    logic              sda_drv;
    logic              hi_matched;
    logic              master_ack;

    logic byte_end, deliver, take_release;
    logic match7, hi_ok, lo_ok;

    i2c_line_sampler #(.STAGES(SYNC_STAGES)) sampler_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rx_holding #(.W(BYTE_W)) rxbuf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .deliver_i (deliver),
        .byte_i    (rx_shift),
        .pop_i     (rx_read_i),
        .ovf_clr_i (rx_ovf_clr_i),
        .data_o    (rx_data_o),
        .full_o    (rx_full_o),
        .ovf_o     (rx_ovf_o),
        .irq_o     (rx_irq_o)
    );

    // Address comparisons on the completed shift register contents.
    assign match7 = rx_shift[BYTE_W-1:1] == own_addr_i[6:0];
    assign hi_ok  = (rx_shift[7:3] == HI_TAG) && (rx_shift[2:1] == own_addr_i[9:8]);
    assign lo_ok  = rx_shift == own_addr_i[7:0];

    assign byte_end     = (state == ST_RX) && scl_fall && (bit_cnt == CNT_FULL);
    assign deliver      = byte_end && (kind == RX_DATA);
    assign take_release = (state == ST_TX) && stretch && clk_release_i && tx_full_o;

    // Transmit holding register and its loaded flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold   <= '0;
            tx_full_o <= 1'b0;
        end else if (tx_load_i) begin
            tx_hold   <= tx_data_i;
            tx_full_o <= 1'b1;
        end else if (take_release) begin
            tx_full_o <= 1'b0;
        end
    end

    // Transfer sequencer: addressing, ACK, receive and transmit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            kind       <= RX_ADDR1;
            after      <= NX_DATA_W;
            bit_cnt    <= '0;
            rx_shift   <= '0;
            tx_shift   <= '0;
            stretch    <= 1'b0;
            sda_drv    <= 1'b0;
            hi_matched <= 1'b0;
            master_ack <= 1'b0;
            selected_o <= 1'b0;
            dir_read_o <= 1'b0;
        end else if (stop_det) begin
            state      <= ST_IDLE;
            stretch    <= 1'b0;
            sda_drv    <= 1'b0;
            hi_matched <= 1'b0;
            selected_o <= 1'b0;
            dir_read_o <= 1'b0;
        end else if (start_det) begin
            state      <= ST_RX;
            kind       <= RX_ADDR1;
            bit_cnt    <= '0;
            stretch    <= 1'b0;
            sda_drv    <= 1'b0;
            selected_o <= 1'b0;
            dir_read_o <= 1'b0;
        end else begin
            unique case (state)
                ST_RX: begin
                    if (scl_rise && bit_cnt != CNT_FULL) begin
                        rx_shift <= {rx_shift[BYTE_W-2:0], sda_s};
                        bit_cnt  <= bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        state <= ST_IGNORE;
                        unique case (kind)
                            RX_ADDR1: begin
                                if (!addr10_i) begin
                                    if (match7) begin
                                        state      <= ST_ACK_OUT;
                                        sda_drv    <= 1'b1;
                                        selected_o <= 1'b1;
                                        dir_read_o <= rx_shift[0];
                                        after      <= rx_shift[0] ? NX_READ : NX_DATA_W;
                                    end
                                end else if (hi_ok && !rx_shift[0]) begin
                                    state   <= ST_ACK_OUT;
                                    sda_drv <= 1'b1;
                                    after   <= NX_ADDR2;
                                end else if (hi_ok && hi_matched) begin
                                    state      <= ST_ACK_OUT;
                                    sda_drv    <= 1'b1;
                                    selected_o <= 1'b1;
                                    dir_read_o <= 1'b1;
                                    after      <= NX_READ;
                                end
                            end
                            RX_ADDR2: begin
                                hi_matched <= lo_ok;
                                if (lo_ok) begin
                                    state      <= ST_ACK_OUT;
                                    sda_drv    <= 1'b1;
                                    selected_o <= 1'b1;
                                    dir_read_o <= 1'b0;
                                    after      <= NX_DATA_W;
                                end
                            end
                            default: begin
                                if (!rx_full_o) begin
                                    state   <= ST_ACK_OUT;
                                    sda_drv <= 1'b1;
                                    after   <= NX_DATA_W;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK_OUT: begin
                    if (scl_fall) begin
                        sda_drv <= 1'b0;
                        bit_cnt <= '0;
                        unique case (after)
                            NX_ADDR2: begin state <= ST_RX; kind <= RX_ADDR2; end
                            NX_READ:  begin state <= ST_TX; stretch <= 1'b1; end
                            default:  begin state <= ST_RX; kind <= RX_DATA; end
                        endcase
                    end
                end
                ST_TX: begin
                    if (stretch) begin
                        if (take_release) begin
                            stretch  <= 1'b0;
                            tx_shift <= tx_hold;
                            sda_drv  <= ~tx_hold[BYTE_W-1];
                            bit_cnt  <= '0;
                        end
                    end else if (scl_fall) begin
                        if (bit_cnt == CNT_LAST) begin
                            sda_drv <= 1'b0;
                            state   <= ST_ACK_IN;
                        end else begin
                            sda_drv  <= ~tx_shift[BYTE_W-2];
                            tx_shift <= tx_shift << 1;
                            bit_cnt  <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_ACK_IN: begin
                    if (scl_rise) begin
                        master_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (master_ack) begin
                            state   <= ST_TX;
                            stretch <= 1'b1;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign scl_drive_low_o = stretch;
    assign sda_drive_low_o = sda_drv;

    AST_NACK_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovf_o) |-> !sda_drive_low_o); // R8
    AST_HOLD_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive_low_o) |-> ($past(clk_release_i && tx_full_o) || $past(start_det || stop_det))); // R9
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_drive_low_o)); // R11
    AST_IRQ_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_o |-> $past(selected_o)); // R4
endmodule

// File: tb/i2c_target_port_tb_top.sv
// Directed bench: a bus master model drives open-drain SCL/SDA and each
// task runs one scenario and checks its own results.
module i2c_target_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int WDOG_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       addr10 = 1'b0;
    logic [9:0] own_addr = 10'h052;
    logic [7:0] tx_data = 8'h00;
    logic       tx_load = 1'b0;
    logic       clk_release = 1'b0;
    logic       rx_read = 1'b0;
    logic       ovf_clr = 1'b0;

    logic       scl_drive_low, sda_drive_low, tx_full, rx_full, rx_irq, rx_ovf;
    logic       selected, dir_read;
    logic [7:0] rx_data;
    logic       scl_line, sda_line;

    int n_checks = 0;
    int n_err    = 0;
    int irq_cnt  = 0;
    int sda_viol = 0;
    int cycles   = 0;

    assign scl_line = !(m_scl_low || scl_drive_low);
    assign sda_line = !(m_sda_low || sda_drive_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_target_port dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_line),
        .sda_i           (sda_line),
        .scl_drive_low_o (scl_drive_low),
        .sda_drive_low_o (sda_drive_low),
        .addr10_i        (addr10),
        .own_addr_i      (own_addr),
        .tx_data_i       (tx_data),
        .tx_load_i       (tx_load),
        .clk_release_i   (clk_release),
        .tx_full_o       (tx_full),
        .rx_data_o       (rx_data),
        .rx_full_o       (rx_full),
        .rx_read_i       (rx_read),
        .rx_irq_o        (rx_irq),
        .rx_ovf_o        (rx_ovf),
        .rx_ovf_clr_i    (ovf_clr),
        .selected_o      (selected),
        .dir_read_o      (dir_read)
    );

    // Interrupt pulse counter and R11 monitor: SDA drive must not move while SCL is high.
    logic prev_scl = 1'b1;
    logic prev_sda_drv = 1'b0;
    always @(negedge clk) begin
        if (rst_n && rx_irq) irq_cnt++;
        if (rst_n && prev_scl && scl_line && (prev_sda_drv != sda_drive_low)) sda_viol++;
        prev_scl     <= scl_line;
        prev_sda_drv <= sda_drive_low;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WDOG_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_release();
        @(negedge clk) clk_release = 1'b1;
        @(negedge clk) clk_release = 1'b0;
    endtask

    task automatic load_tx(input logic [7:0] b);
        @(negedge clk) begin tx_data = b; tx_load = 1'b1; end
        @(negedge clk) tx_load = 1'b0;
    endtask

    task automatic pulse_read();
        @(negedge clk) rx_read = 1'b1;
        @(negedge clk) rx_read = 1'b0;
    endtask

    task automatic pulse_ovf_clr();
        @(negedge clk) ovf_clr = 1'b1;
        @(negedge clk) ovf_clr = 1'b0;
    endtask

    // One SCL clock: present a bit, raise SCL (waiting out a hold), sample SDA, lower SCL.
    task automatic clock_bit(input logic b, output logic seen);
        m_sda_low = !b;
        wait_cyc(Q);
        m_scl_low = 1'b0;
        while (!scl_line) @(negedge clk);
        wait_cyc(Q);
        seen = sda_line;
        m_scl_low = 1'b1;
        wait_cyc(Q);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b1;
        wait_cyc(Q);
        m_scl_low = 1'b1;
        wait_cyc(Q);
    endtask

    task automatic bus_rstart();
        m_sda_low = 1'b0;
        wait_cyc(Q);
        m_scl_low = 1'b0;
        while (!scl_line) @(negedge clk);
        wait_cyc(Q);
        m_sda_low = 1'b1;
        wait_cyc(Q);
        m_scl_low = 1'b1;
        wait_cyc(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1;
        wait_cyc(Q);
        m_scl_low = 1'b0;
        while (!scl_line) @(negedge clk);
        wait_cyc(Q);
        m_sda_low = 1'b0;
        wait_cyc(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(!give_ack, s);
    endtask

    task automatic t_reset();
        check("R1", "scl drive", 32'(scl_drive_low), 0);
        check("R1", "sda drive", 32'(sda_drive_low), 0);
        check("R1", "rx_full", 32'(rx_full), 0);
        check("R1", "rx_ovf", 32'(rx_ovf), 0);
        check("R1", "selected", 32'(selected), 0);
        check("R1", "tx_full", 32'(tx_full), 0);
        check("R1", "irq count", 32'(irq_cnt), 0);
    endtask

    task automatic t_write7();
        logic a;
        int base;
        addr10 = 1'b0; own_addr = 10'h052;
        base = irq_cnt;
        bus_start();
        write_byte(8'hA4, a);
        check("R3", "ack of 7-bit write address", 32'(a), 1);
        check("R3", "selected", 32'(selected), 1);
        check("R3", "dir_read", 32'(dir_read), 0);
        write_byte(8'h5A, a);
        check("R7", "ack of data", 32'(a), 1);
        check("R7", "rx_data", 32'(rx_data), 32'h5A);
        check("R7", "rx_full", 32'(rx_full), 1);
        check("R7", "one irq cycle", 32'(irq_cnt - base), 1);
        pulse_read();
        check("R7", "rx_full after read", 32'(rx_full), 0);
        write_byte(8'hC3, a);
        check("R7", "second data", {23'd0, a, rx_data}, {23'd0, 1'b1, 8'hC3});
        pulse_read();
        bus_stop();
        check("R2", "selected after STOP", 32'(selected), 0);
        check("R2", "lines free after STOP", {30'd0, scl_drive_low, sda_drive_low}, 0);
    endtask

    task automatic t_mismatch7();
        logic a;
        int base;
        base = irq_cnt;
        bus_start();
        write_byte(8'hA6, a);
        check("R4", "no ack on wrong address", 32'(a), 0);
        check("R4", "not selected", 32'(selected), 0);
        write_byte(8'h77, a);
        check("R4", "no ack on later byte", 32'(a), 0);
        check("R4", "no irq", 32'(irq_cnt - base), 0);
        check("R4", "buffer empty", 32'(rx_full), 0);
        bus_stop();
    endtask

    task automatic t_overflow();
        logic a;
        bus_start();
        write_byte(8'hA4, a);
        write_byte(8'h11, a);
        check("R8", "first byte acked", 32'(a), 1);
        write_byte(8'h22, a);
        check("R8", "overflow byte NACKed", 32'(a), 0);
        check("R8", "ovf set", 32'(rx_ovf), 1);
        check("R8", "buffer kept", 32'(rx_data), 32'h11);
        bus_stop();
        check("R8", "ovf sticky", 32'(rx_ovf), 1);
        pulse_ovf_clr();
        check("R8", "ovf cleared", 32'(rx_ovf), 0);
        pulse_read();
    endtask

    task automatic t_read7();
        logic a;
        logic [7:0] b;
        bus_start();
        write_byte(8'hA5, a);
        check("R3", "ack of read address", 32'(a), 1);
        check("R3", "dir_read", 32'(dir_read), 1);
        m_scl_low = 1'b0;
        wait_cyc(20);
        check("R9", "SCL held after read address", 32'(scl_line), 0);
        pulse_release();
        wait_cyc(20);
        check("R9", "release with empty tx ignored", 32'(scl_line), 0);
        load_tx(8'h96);
        check("R9", "tx_full after load", 32'(tx_full), 1);
        pulse_release();
        wait_cyc(4);
        check("R9", "SCL freed after load+release", 32'(scl_line), 1);
        check("R9", "tx_full cleared", 32'(tx_full), 0);
        read_byte(1'b1, b);
        check("R10", "first read byte", 32'(b), 32'h96);
        m_scl_low = 1'b0;
        wait_cyc(20);
        check("R10", "SCL held after master ACK", 32'(scl_line), 0);
        load_tx(8'h0F);
        pulse_release();
        read_byte(1'b0, b);
        check("R10", "second read byte", 32'(b), 32'h0F);
        read_byte(1'b0, b);
        check("R10", "SDA released after NACK", 32'(b), 32'hFF);
        bus_stop();
    endtask

    task automatic t_10bit_good();
        logic a;
        logic [7:0] b;
        addr10 = 1'b1; own_addr = 10'h2A5;
        bus_start();
        write_byte(8'hF4, a);
        check("R5", "ack of 10-bit header", 32'(a), 1);
        write_byte(8'hA5, a);
        check("R5", "ack of low address", 32'(a), 1);
        check("R5", "selected", 32'(selected), 1);
        write_byte(8'h3C, a);
        check("R5", "data after 10-bit match", {23'd0, a, rx_data}, {23'd0, 1'b1, 8'h3C});
        pulse_read();
        bus_rstart();
        check("R2", "repeated START clears selection", 32'(selected), 0);
        write_byte(8'hF5, a);
        check("R6", "ack of read header after match", 32'(a), 1);
        check("R6", "dir_read", 32'(dir_read), 1);
        load_tx(8'hE1);
        pulse_release();
        read_byte(1'b0, b);
        check("R6", "10-bit read data", 32'(b), 32'hE1);
        bus_stop();
    endtask

    task automatic t_10bit_bad();
        logic a;
        bus_start();
        write_byte(8'hF4, a);
        write_byte(8'hA4, a);
        check("R5", "wrong low address NACKed", 32'(a), 0);
        bus_rstart();
        write_byte(8'hF5, a);
        check("R6", "read header without match NACKed", 32'(a), 0);
        bus_stop();
        bus_start();
        write_byte(8'hF5, a);
        check("R6", "read header after STOP NACKed", 32'(a), 0);
        bus_stop();
        bus_start();
        write_byte(8'hF6, a);
        check("R5", "wrong bits 9:8 NACKed", 32'(a), 0);
        bus_stop();
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset();
        t_write7();
        t_mismatch7();
        t_overflow();
        t_read7();
        t_10bit_good();
        t_10bit_bad();
        check("R11", "SDA drive moved while SCL high", 32'(sda_viol), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule